// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry/Link Flags

This unit moves the bits of a 16-bit or 32-bit operand left or right in one of three ways: a logical shift that fills with zeros, an arithmetic shift that keeps or checks the sign, or a rotate that feeds the bits that leave one end back in at the other. Each operation also yields a status bit that holds the last bit to leave the operand. This bit appears on two outputs, carry and link, which always carry the same value. An arithmetic left shift that changes the sign, or that loses significant bits, raises an integer-overflow request.

The shift count comes in as a 6-bit field that holds the negated count. The unit negates the field again, so the count is always 1 to 64. A 2-bit selector picks the width and the direction. A caller pulses `start_i` together with the operand, the count field, the operation class and the selector. One clock later the unit presents the result, the flags and the overflow request, together with a one-cycle `done_o` pulse. These outputs stay the same until the next start.

Top module: `bitshift_unit`

## Requirements
- R1: The count is n = (64 − field) mod 64, and a value of 0 means 64. Field 0 therefore gives 64, field 63 gives 1 and field 32 gives 32.
- R2: The selector picks the form. 0 is 32-bit left, 1 is 16-bit left, 2 is 32-bit right and 3 is 16-bit right. A 16-bit form uses only `operand_i[15:0]` and returns zeros in `result_o[31:16]`.
- R3: The result, the flags and the overflow request are registered. They appear one cycle after `start_i`, together with a single-cycle `done_o`, and they hold while `start_i` is low.
- R4: Logical right shift (class 0). For n ≤ width, the result is the operand shifted right with zero fill, and the flag is operand bit n−1. For n > width, the result is 0 and the flag is 0.
- R5: Logical left shift (class 0). For n ≤ width, the result is the operand shifted left, and the flag is operand bit width−n. For n > width, the result is 0 and the flag is 0.
- R6: Arithmetic right shift (class 1). For n ≤ width, the result is filled with the sign bit, and the flag is operand bit n−1. For n > width, a negative operand gives all ones with the flag set, and any other operand gives 0 with the flag clear.
- R7: Arithmetic left shift (class 1). For n < width, the result is the operand shifted left. The flag is set when the operand bits from width−1 down to width−1−n are not all equal. For n ≥ width, the result is 0 and the flag is set exactly when the operand was nonzero.
- R8: Rotate (class 2). The effective count is ((n−1) mod width)+1. The result is the operand rotated by that count. The flag is the last bit rotated out: bit width−m for a left rotate by m, and bit m−1 for a right rotate by m.
- R9: The carry and link outputs are always equal. Each starts cleared for every operation and is set only by the rules of R4 to R8.
- R10: The overflow request is set only by an arithmetic left shift, and then it equals the flag.
- R11: Class code 3 behaves exactly like class 0, the logical shift.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; the inputs are taken on this cycle |
| operand_i | input | 32 | Operand; a 16-bit form uses bits 15:0 |
| cnt_field_i | input | 6 | Negated count field |
| op_class_i | input | 2 | 0 logical, 1 arithmetic, 2 rotate, 3 logical |
| sel_i | input | 2 | Bit 0 selects 16-bit width; bit 1 selects right |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Last bit shifted out |
| link_o | output | 1 | Copy of the carry flag |
| ovf_req_o | output | 1 | Integer-overflow request |
| done_o | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
Every result of this unit is due exactly one clock edge after the edge that samples `start_i`: the result, both flags, the overflow request and `done_o` all come out of the same register. The bench keeps a behavioural model that steps one bit at a time and updates it on the same edge. On every falling edge it compares all outputs with that model, so the one-cycle latency, the single-cycle done pulse and the holding of the outputs between starts are all checked at the right time. The stimulus covers every selector and class with counts 1, 5, 15, 16, 17, 31, 32, 33 and 64, and leaves idle cycles between some operations.

// File: rtl/bitshift_pkg.sv
package bitshift_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int CNT_FIELD_W = 6;
    localparam int CNT_W       = CNT_FIELD_W + 1;

    typedef enum logic [1:0] {
        SH_LOGIC  = 2'd0,
        SH_ARITH  = 2'd1,
        SH_ROTATE = 2'd2,
        SH_SPARE  = 2'd3
    } shift_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              flag;
        logic              ovf;
        logic              done;
    } shift_state_t;

endpackage

// File: rtl/shift_count_decode.sv
module shift_count_decode #(
    parameter int FW = 6
) (
    input  logic [FW-1:0] field_i,
    output logic [FW:0]   count_o
);
    logic [FW-1:0] neg;

    always_comb begin
        neg = '0 - field_i;
        if (neg == '0) begin
            count_o = {1'b1, {FW{1'b0}}};
        end else begin
            count_o = {1'b0, neg};
        end
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import bitshift_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 7
) (
    input  logic [W-1:0]  val_i,
    input  logic [CW-1:0] cnt_i,
    input  shift_class_e  class_i,
    input  logic          left_i,
    output logic [W-1:0]  res_o,
    output logic          flag_o,
    output logic          ovf_o
);
    localparam logic [W-1:0] ONES = '1;

    int           n;
    int           rot;
    logic [W-1:0] tmp;
    logic [W-1:0] win_mask;
    logic [W-1:0] win;

    always_comb begin
        n        = int'(cnt_i);
        rot      = ((n - 1) % W) + 1;
        res_o    = '0;
        flag_o   = 1'b0;
        ovf_o    = 1'b0;
        tmp      = '0;
        win_mask = ~(ONES >> (n + 1));
        win      = val_i & win_mask;
        case (class_i)
            SH_ROTATE: begin
                if (left_i) begin
                    res_o = (val_i << rot) | (val_i >> (W - rot));
                    tmp   = val_i >> (W - rot);
                end else begin
                    res_o = (val_i >> rot) | (val_i << (W - rot));
                    tmp   = val_i >> (rot - 1);
                end
                flag_o = tmp[0];
            end
            SH_ARITH: begin
                if (left_i) begin
                    if (n < W) begin
                        res_o  = val_i << n;
                        flag_o = (win != '0) && (win != win_mask);
                    end else begin
                        res_o  = '0;
                        flag_o = |val_i;
                    end
                    ovf_o = flag_o;
                end else begin
                    if (n <= W) begin
                        res_o  = $signed(val_i) >>> n;
                        tmp    = val_i >> (n - 1);
                        flag_o = tmp[0];
                    end else begin
                        res_o  = {W{val_i[W-1]}};
                        flag_o = val_i[W-1];
                    end
                end
            end
            default: begin
                if (n <= W) begin
                    if (left_i) begin
                        res_o = val_i << n;
                        tmp   = val_i >> (W - n);
                    end else begin
                        res_o = val_i >> n;
                        tmp   = val_i >> (n - 1);
                    end
                    flag_o = tmp[0];
                end
            end
        endcase
    end
endmodule

// File: rtl/bitshift_unit.sv
module bitshift_unit
    import bitshift_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [31:0] operand_i,
    input  logic [5:0]  cnt_field_i,
    input  logic [1:0]  op_class_i,
    input  logic [1:0]  sel_i,
    output logic [31:0] result_o,
    output logic        carry_o,
    output logic        link_o,
    output logic        ovf_req_o,
    output logic        done_o
);
    localparam int PAD_W = DATA_W - HALF_W;

    logic [CNT_W-1:0]  count;
    shift_class_e      cls;
    logic              left;
    logic [DATA_W-1:0] wide_res;
    logic              wide_flag;
    logic              wide_ovf;
    logic [HALF_W-1:0] half_res;
    logic              half_flag;
    logic              half_ovf;
    shift_state_t      state_d;
    shift_state_t      state_q;

    assign cls  = shift_class_e'(op_class_i);
    assign left = ~sel_i[1];

    shift_count_decode #(.FW(CNT_FIELD_W)) u_decode (
        .field_i (cnt_field_i),
        .count_o (count)
    );

    shift_core #(.W(DATA_W), .CW(CNT_W)) u_wide (
        .val_i   (operand_i),
        .cnt_i   (count),
        .class_i (cls),
        .left_i  (left),
        .res_o   (wide_res),
        .flag_o  (wide_flag),
        .ovf_o   (wide_ovf)
    );

    shift_core #(.W(HALF_W), .CW(CNT_W)) u_half (
        .val_i   (operand_i[HALF_W-1:0]),
        .cnt_i   (count),
        .class_i (cls),
        .left_i  (left),
        .res_o   (half_res),
        .flag_o  (half_flag),
        .ovf_o   (half_ovf)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (start_i) begin
            state_d.done = 1'b1;
            if (sel_i[0]) begin
                state_d.result = {{PAD_W{1'b0}}, half_res};
                state_d.flag   = half_flag;
                state_d.ovf    = half_ovf;
            end else begin
                state_d.result = wide_res;
                state_d.flag   = wide_flag;
                state_d.ovf    = wide_ovf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o  = state_q.result;
    assign carry_o   = state_q.flag;
    assign link_o    = state_q.flag;
    assign ovf_req_o = state_q.ovf;
    assign done_o    = state_q.done;
endmodule

// File: rtl/bitshift_unit_chk.sv
module bitshift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [5:0]  cnt_field_i,
    input logic [1:0]  op_class_i,
    input logic [1:0]  sel_i,
    input logic [31:0] result_o,
    input logic        carry_o,
    input logic        ovf_req_o,
    input logic        done_o
);
    // R3
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    // R3
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o) && $stable(carry_o) && $stable(ovf_req_o));

    // R2
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && sel_i[0]) |=> (result_o[31:16] == 16'h0000));

    // R10
    ovf_only_arith_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !(op_class_i == 2'd1 && !sel_i[1])) |=> !ovf_req_o);

    // R5
    wide_logic_left_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_class_i == 2'd0 && sel_i == 2'd0 && cnt_field_i < 6'd32)
        |=> (result_o == 32'h0) && !carry_o);
endmodule

bind bitshift_unit bitshift_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cnt_field_i (cnt_field_i),
    .op_class_i  (op_class_i),
    .sel_i       (sel_i),
    .result_o    (result_o),
    .carry_o     (carry_o),
    .ovf_req_o   (ovf_req_o),
    .done_o      (done_o)
);

// File: tb/bitshift_unit_tb.sv
module bitshift_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] operand_i = '0;
    logic [5:0]  cnt_field_i = '0;
    logic [1:0]  op_class_i = '0;
    logic [1:0]  sel_i = '0;
    logic [31:0] result_o;
    logic        carry_o, link_o, ovf_req_o, done_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    logic [31:0] exp_res = '0;
    logic        exp_flag = 1'b0;
    logic        exp_ovf = 1'b0;
    logic        exp_done = 1'b0;
    string       cur_tag = "R12";
    string       exp_tag = "R12";

    always #(CLK_PERIOD/2) clk = ~clk;

    bitshift_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .cnt_field_i(cnt_field_i), .op_class_i(op_class_i), .sel_i(sel_i),
        .result_o(result_o), .carry_o(carry_o), .link_o(link_o),
        .ovf_req_o(ovf_req_o), .done_o(done_o)
    );

    // Behavioural model: moves one bit per step.
    function automatic void model(input logic [31:0] v, input logic [5:0] f,
                                  input logic [1:0] cls, input logic [1:0] sel,
                                  output logic [31:0] r, output logic c, output logic o);
        int n = (64 - int'(f)) % 64;
        int w = sel[0] ? 16 : 32;
        bit left = !sel[1];
        logic [31:0] mask = sel[0] ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        logic [31:0] x = v & mask;
        logic sgn;
        logic b;
        if (n == 0) n = 64;
        sgn = x[w-1];
        c = 1'b0;
        o = 1'b0;
        if (cls == 2'd2) begin
            for (int i = 0; i < ((n - 1) % w) + 1; i++) begin
                if (left) begin
                    b = x[w-1];
                    x = ((x << 1) | {31'b0, b}) & mask;
                end else begin
                    b = x[0];
                    x = (x >> 1) | ({31'b0, b} << (w - 1));
                end
                c = b;
            end
        end else if (cls == 2'd1 && left) begin
            if (n < w) begin
                for (int i = 0; i <= n; i++)
                    if (x[w-1-i] != x[w-1]) c = 1'b1;
                for (int i = 0; i < n; i++) x = (x << 1) & mask;
            end else begin
                c = (x != 0);
                x = 0;
            end
            o = c;
        end else if (cls == 2'd1) begin
            for (int i = 0; i < n; i++) begin
                c = x[0];
                x = (x >> 1) | ({31'b0, sgn} << (w - 1));
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                if (left) begin
                    c = x[w-1];
                    x = (x << 1) & mask;
                end else begin
                    c = x[0];
                    x = x >> 1;
                end
            end
        end
        r = x;
    endfunction

    // Cycle model updated on the same edge as the design register.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_res <= '0; exp_flag <= 1'b0; exp_ovf <= 1'b0; exp_done <= 1'b0;
            exp_tag <= "R12";
        end else begin
            logic [31:0] r;
            logic c, o;
            exp_done <= start_i;
            if (start_i) begin
                model(operand_i, cnt_field_i, op_class_i, sel_i, r, c, o);
                exp_res <= r; exp_flag <= c; exp_ovf <= o; exp_tag <= cur_tag;
            end
        end
    end

    // Compare every output on every falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (result_o !== exp_res) begin
                failures++;
                $display("FAIL %s/R2 result act=%h exp=%h", exp_tag, result_o, exp_res);
            end
            checks++;
            if (carry_o !== exp_flag || link_o !== exp_flag) begin
                failures++;
                $display("FAIL %s/R9 flags act=%b/%b exp=%b", exp_tag, carry_o, link_o, exp_flag);
            end
            checks++;
            if (ovf_req_o !== exp_ovf) begin
                failures++;
                $display("FAIL %s/R10 ovf act=%b exp=%b", exp_tag, ovf_req_o, exp_ovf);
            end
            checks++;
            if (done_o !== exp_done) begin
                failures++;
                $display("FAIL R3 done act=%b exp=%b", done_o, exp_done);
            end
        end
    end

    task automatic issue(input logic [31:0] v, input int n, input logic [1:0] cls,
                         input logic [1:0] sel, input int idle);
        string t;
        case (cls)
            2'd0: t = sel[1] ? "R4" : "R5";
            2'd1: t = sel[1] ? "R6" : "R7";
            2'd2: t = "R8";
            default: t = "R11";
        endcase
        if (n == 64) t = {t, " R1"};
        @(negedge clk);
        operand_i   = v;
        cnt_field_i = 6'((64 - n) % 64);
        op_class_i  = cls;
        sel_i       = sel;
        cur_tag     = t;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        operand_i = ~v;
        for (int k = 0; k < idle; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                failures++;
                $display("FAIL watchdog expired at cycle %0d", cycles);
                finished = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] vals [6] = '{32'h8000_0001, 32'h1234_5678, 32'h0000_4000,
                                  32'hFFFF_FFFF, 32'h7FFF_8000, 32'h0000_0000};
        int cnts [9] = '{1, 5, 15, 16, 17, 31, 32, 33, 64};
        repeat (3) @(negedge clk);   // R12 reset state compared meanwhile
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 4; c++)
                for (int v = 0; v < 6; v++)
                    for (int k = 0; k < 9; k++)
                        issue(vals[v], cnts[k], 2'(c), 2'(s), (k % 3 == 0) ? 2 : 0);
        // R7: 16-bit arithmetic left, sign kept vs. lost
        issue(32'h0000_1000, 2, 2'd1, 2'd1, 1);
        issue(32'h0000_2000, 2, 2'd1, 2'd1, 1);
        // R8: 16-bit rotate of a 32-bit count reduces mod 16
        issue(32'h0000_8001, 20, 2'd2, 2'd3, 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule